// File: doc/BRIEF.md
# CAN Controller Mode and Interrupt Register Core

This block is the register-mapped control core of a CAN controller. Software reaches it over a simple 32-bit word bus. Writes take effect on the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`. The block holds these registers:

- a control register with a soft-reset bit and an enable bit;
- a mode request register;
- the bit-rate prescaler and the bit-timing registers;
- a read-only status register;
- a sticky interrupt status register, an interrupt enable register and a write-one-to-clear register.

The operating mode moves between configuration, normal, loopback and sleep. Software requests a mode change by writing a register. The mode that actually results is visible only through the status register and `opmode_o`. The protocol engine and the FIFOs sit outside this block. They report events as single-cycle pulses on `evt_i`. Each pulse uses the bit position of the interrupt it raises. They also report error levels on dedicated inputs, and they take the bit-timing values from `brp_o` and `btim_o`. `irq_o` is a level interrupt.

Top module: `canctl_regs`

## Requirements
- R1: After hard reset, and after a write to offset 0x00 with bit 0 set, the following hold:
  - status (0x18) reads exactly 0x00000001;
  - control, mode, prescaler, bit-timing, interrupt status and interrupt enable all read 0;
  - the soft-reset bit always reads 0.
- R2: Writing 0x00 with bit 1 = 1 and bit 0 = 0, while in configuration and with mode bit 1 (loopback request) = 0, enters normal mode. Status then reads bit 3 only, and control bit 1 reads 1.
- R3: The same enable write with the loopback request at 1 enters loopback mode, and status bit 1 goes high.
- R4: Sleep and wake behave as follows:
  - In normal mode with mode bit 0 (sleep request) = 1, the block enters sleep one cycle later, and status bit 2 is set.
  - A wake event (evt_i bit 11) in sleep returns the block to normal mode and clears the sleep request.
- R5: Writing 0x00 with bit 1 = 0 in any mode returns the block to configuration mode.
- R6: A bus-off event (evt_i bit 9) has these effects:
  - the block returns to configuration mode;
  - control bit 1 reads 0;
  - interrupt status bit 9 is set.
- R7: The prescaler (0x08, 8 bits) and bit-timing (0x0C, 9 bits) registers accept writes only in configuration mode. In any other mode their value stays unchanged.
- R8: An event pulse on evt_i sets the matching sticky bit of interrupt status (0x1C). The bits that exist are 0, 1, 2, 4, 6, 7, 8, 9, 10, 11 and 14 (mask 0x4FD7). All other bits read 0.
- R9: Writing 1s to offset 0x24 clears those interrupt status bits, and 0s have no effect. An event and a clear on the same bit in the same cycle leaves the bit set. Offset 0x24 reads 0.
- R10: The interrupt enable register (0x20) holds only the bits that exist in the interrupt status register. irq_o is high exactly when some bit is set in both the interrupt status and the interrupt enable registers.
- R11: Status bit 6 reports the error warning, bits 8:7 the error state and bit 10 TX queue full. All three fields read 0 while in configuration mode.
- R12: Unmapped offsets read 0. Writes to status (0x18) and interrupt status (0x1C) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| evt_i | input | IRQ_W | Event pulses, positioned as the interrupt bits |
| err_warn_i | input | 1 | Error warning level from the engine |
| err_state_i | input | 2 | Error state from the engine |
| txq_full_i | input | 1 | TX queue full level |
| brp_o | output | BRP_W | Prescaler value to the engine |
| btim_o | output | BT_W | Bit-timing value to the engine |
| opmode_o | output | 2 | Mode: 0 configuration, 1 normal, 2 loopback, 3 sleep |
| irq_o | output | 1 | Level interrupt |

## Verification
Two pairs of functions can coincide in one cycle:

- **Event and clear on the same bit.** The bench drives an event pulse on evt_i bit 0 together with a write of 1 to that bit of the clear register. It then expects the status bit to remain set.
- **Bus-off and a mode change.** A bus-off pulse arrives while other event bits are also raised. The mode must fall back to configuration while every event still latches.

A behavioural model in the bench follows both outcomes every clock and compares them against the bus read data, irq_o and the mode output.

// File: rtl/cmc_pkg.sv
package cmc_pkg;
   // register offsets (bytes)
   localparam logic [7:0] OFF_CTRL = 8'h00;
   localparam logic [7:0] OFF_MODE = 8'h04;
   localparam logic [7:0] OFF_BRP  = 8'h08;
   localparam logic [7:0] OFF_BTIM = 8'h0C;
   localparam logic [7:0] OFF_STAT = 8'h18;
   localparam logic [7:0] OFF_ISR  = 8'h1C;
   localparam logic [7:0] OFF_IER  = 8'h20;
   localparam logic [7:0] OFF_ICLR = 8'h24;

   // event / interrupt bit positions that change the mode
   localparam int EV_BUSOFF = 9;
   localparam int EV_WAKE   = 11;
   localparam int EV_MIN_W  = 15;

   // interrupt bits that exist
   localparam logic [31:0] IRQ_IMPL_MASK = 32'h0000_4FD7;

   typedef enum logic [1:0] {
      MD_CFG   = 2'd0,
      MD_NORM  = 2'd1,
      MD_LOOP  = 2'd2,
      MD_SLEEP = 2'd3
   } op_mode_t;
endpackage

// File: rtl/cmc_mode_seq.sv
module cmc_mode_seq
   import cmc_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     soft_rst,
   input  logic     busoff_evt,
   input  logic     ctrl_wr,
   input  logic     en_val,
   input  logic     lback_req,
   input  logic     sleep_req,
   input  logic     wake_evt,
   output op_mode_t mode_o,
   output logic     wake_taken_o
);
   op_mode_t mode_q, mode_d;

   always_comb begin
      mode_d = mode_q;
      if (soft_rst || busoff_evt) begin
         mode_d = MD_CFG;
      end else if (ctrl_wr) begin
         if (!en_val)
            mode_d = MD_CFG;
         else if (mode_q == MD_CFG)
            mode_d = lback_req ? MD_LOOP : MD_NORM;
      end else if (mode_q == MD_NORM && sleep_req) begin
         mode_d = MD_SLEEP;
      end else if (mode_q == MD_SLEEP && wake_evt) begin
         mode_d = MD_NORM;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= MD_CFG;
      else        mode_q <= mode_d;
   end

   assign mode_o       = mode_q;
   assign wake_taken_o = (mode_q == MD_SLEEP) && (mode_d == MD_NORM);

   // R1
   soft_rst_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> mode_q == MD_CFG);
   // R6
   busoff_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busoff_evt |=> mode_q == MD_CFG);
   // R3
   loop_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && en_val && !soft_rst && !busoff_evt && mode_q == MD_CFG && lback_req)
      |=> mode_q == MD_LOOP);
   // R4
   wake_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MD_SLEEP && wake_evt && !soft_rst && !busoff_evt && !ctrl_wr)
      |=> mode_q == MD_NORM);
endmodule

// File: rtl/cmc_irq_bank.sv
module cmc_irq_bank #(
   parameter int               IRQ_W = 15,
   parameter logic [IRQ_W-1:0] IMPL  = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic [IRQ_W-1:0] evt,
   input  logic             clr_wr,
   input  logic [IRQ_W-1:0] clr_bits,
   input  logic             ier_wr,
   input  logic [IRQ_W-1:0] ier_bits,
   output logic [IRQ_W-1:0] isr_o,
   output logic [IRQ_W-1:0] ier_o,
   output logic             irq_o
);
   for (genvar i = 0; i < IRQ_W; i++) begin : g_bit
      if (IMPL[i]) begin : g_live
         logic st_q, en_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               st_q <= 1'b0;
               en_q <= 1'b0;
            end else if (soft_rst) begin
               st_q <= 1'b0;
               en_q <= 1'b0;
            end else begin
               // set wins over a same-cycle clear
               st_q <= evt[i] | (st_q & ~(clr_wr & clr_bits[i]));
               if (ier_wr) en_q <= ier_bits[i];
            end
         end
         assign isr_o[i] = st_q;
         assign ier_o[i] = en_q;
      end else begin : g_dead
         assign isr_o[i] = 1'b0;
         assign ier_o[i] = 1'b0;
      end
   end

   assign irq_o = |(isr_o & ier_o);

   // R8
   evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((|(evt & IMPL)) && !soft_rst)
      |=> ((isr_o & $past(evt & IMPL)) == $past(evt & IMPL)));
   // R9
   clear_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && !soft_rst) |=> ((isr_o & $past(clr_bits & ~evt)) == '0));
endmodule

// File: rtl/canctl_regs.sv
module canctl_regs
   import cmc_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int IRQ_W  = 15,
   parameter int BRP_W  = 8,
   parameter int BT_W   = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [IRQ_W-1:0]  evt_i,
   input  logic              err_warn_i,
   input  logic [1:0]        err_state_i,
   input  logic              txq_full_i,
   output logic [BRP_W-1:0]  brp_o,
   output logic [BT_W-1:0]   btim_o,
   output logic [1:0]        opmode_o,
   output logic              irq_o
);
   localparam logic [IRQ_W-1:0] IMPL = IRQ_W'(IRQ_IMPL_MASK);
   localparam int STAT_W = 11;

   if (IRQ_W < EV_MIN_W) begin : g_bad_irq_w
      initial $fatal(1, "IRQ_W must cover every interrupt bit");
   end
   if (DATA_W < 16 || DATA_W < BRP_W || DATA_W < BT_W) begin : g_bad_data_w
      initial $fatal(1, "DATA_W too narrow for the register fields");
   end
   if (ADDR_W < 6) begin : g_bad_addr_w
      initial $fatal(1, "ADDR_W too narrow for the register offsets");
   end

   // write decode
   logic wr_ctrl, wr_mode, wr_brp, wr_btim, wr_ier, wr_iclr;
   assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
   assign wr_mode = bus_wr && (bus_addr == ADDR_W'(OFF_MODE));
   assign wr_brp  = bus_wr && (bus_addr == ADDR_W'(OFF_BRP));
   assign wr_btim = bus_wr && (bus_addr == ADDR_W'(OFF_BTIM));
   assign wr_ier  = bus_wr && (bus_addr == ADDR_W'(OFF_IER));
   assign wr_iclr = bus_wr && (bus_addr == ADDR_W'(OFF_ICLR));

   logic soft_rst, ctrl_wr;
   assign soft_rst = wr_ctrl && bus_wdata[0];
   assign ctrl_wr  = wr_ctrl && !bus_wdata[0];

   // mode requests
   logic     lback_q, sleep_q, wake_taken;
   op_mode_t mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lback_q <= 1'b0;
         sleep_q <= 1'b0;
      end else if (soft_rst) begin
         lback_q <= 1'b0;
         sleep_q <= 1'b0;
      end else if (wr_mode) begin
         lback_q <= bus_wdata[1];
         sleep_q <= bus_wdata[0];
      end else if (wake_taken) begin
         sleep_q <= 1'b0;
      end
   end

   cmc_mode_seq u_mode (
      .clk          (clk),
      .rst_n        (rst_n),
      .soft_rst     (soft_rst),
      .busoff_evt   (evt_i[EV_BUSOFF]),
      .ctrl_wr      (ctrl_wr),
      .en_val       (bus_wdata[1]),
      .lback_req    (lback_q),
      .sleep_req    (sleep_q),
      .wake_evt     (evt_i[EV_WAKE]),
      .mode_o       (mode_q),
      .wake_taken_o (wake_taken)
   );

   // bit timing, gated by configuration mode
   logic [BRP_W-1:0] brp_q;
   logic [BT_W-1:0]  bt_q;
   logic             in_cfg;
   assign in_cfg = (mode_q == MD_CFG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         brp_q <= '0;
         bt_q  <= '0;
      end else if (soft_rst) begin
         brp_q <= '0;
         bt_q  <= '0;
      end else if (in_cfg) begin
         if (wr_brp)  brp_q <= bus_wdata[BRP_W-1:0];
         if (wr_btim) bt_q  <= bus_wdata[BT_W-1:0];
      end
   end

   // interrupts
   logic [IRQ_W-1:0] isr, ier;

   cmc_irq_bank #(.IRQ_W(IRQ_W), .IMPL(IMPL)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .evt      (evt_i),
      .clr_wr   (wr_iclr),
      .clr_bits (bus_wdata[IRQ_W-1:0]),
      .ier_wr   (wr_ier),
      .ier_bits (bus_wdata[IRQ_W-1:0]),
      .isr_o    (isr),
      .ier_o    (ier),
      .irq_o    (irq_o)
   );

   // status word
   logic [STAT_W-1:0] stat;
   always_comb begin
      stat    = '0;
      stat[0] = in_cfg;
      stat[1] = (mode_q == MD_LOOP);
      stat[2] = (mode_q == MD_SLEEP);
      stat[3] = (mode_q == MD_NORM);
      if (!in_cfg) begin
         stat[6]   = err_warn_i;
         stat[8:7] = err_state_i;
         stat[10]  = txq_full_i;
      end
   end

   // read mux
   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(OFF_CTRL): bus_rdata = DATA_W'({!in_cfg, 1'b0});
         ADDR_W'(OFF_MODE): bus_rdata = DATA_W'({lback_q, sleep_q});
         ADDR_W'(OFF_BRP):  bus_rdata = DATA_W'(brp_q);
         ADDR_W'(OFF_BTIM): bus_rdata = DATA_W'(bt_q);
         ADDR_W'(OFF_STAT): bus_rdata = DATA_W'(stat);
         ADDR_W'(OFF_ISR):  bus_rdata = DATA_W'(isr);
         ADDR_W'(OFF_IER):  bus_rdata = DATA_W'(ier);
         default:           bus_rdata = '0;
      endcase
   end

   assign brp_o    = brp_q;
   assign btim_o   = bt_q;
   assign opmode_o = mode_q;

   // R7
   timing_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_cfg && !soft_rst) |=> ($stable(brp_q) && $stable(bt_q)));
endmodule

// File: tb/canctl_regs_bench.sv
module canctl_regs_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  addr = '0;
   logic        wr = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [14:0] evt = '0;
   logic        warn = 1'b0;
   logic [1:0]  est = '0;
   logic        full = 1'b0;
   logic [7:0]  brp;
   logic [8:0]  btim;
   logic [1:0]  opmode;
   logic        irq;

   int total = 0;
   int bad = 0;
   bit done = 0;

   localparam logic [31:0] MASK = 32'h4FD7;

   always #10 clk = ~clk;

   canctl_regs u_canctl_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
      .bus_rdata(rdata), .evt_i(evt), .err_warn_i(warn), .err_state_i(est),
      .txq_full_i(full), .brp_o(brp), .btim_o(btim), .opmode_o(opmode), .irq_o(irq)
   );

   // behavioural reference model
   int          mst;
   logic        ml, ms;
   logic [31:0] mbrp, mbt, mier, misr;

   task automatic m_clear();
      mst = 0; ml = 0; ms = 0; mbrp = 0; mbt = 0; mier = 0; misr = 0;
   endtask

   always @(posedge clk) begin
      if (!rst_n) m_clear();
      else if (wr && addr == 8'h00 && wdata[0]) m_clear();
      else begin
         int  nst;
         bit  woke;
         nst = mst; woke = 0;
         if (evt[9]) nst = 0;
         else if (wr && addr == 8'h00) begin
            if (!wdata[1]) nst = 0;
            else if (mst == 0) nst = ml ? 2 : 1;
         end else if (mst == 1 && ms) nst = 3;
         else if (mst == 3 && evt[11]) begin nst = 1; woke = 1; end
         if (wr && addr == 8'h04) begin ml = wdata[1]; ms = wdata[0]; end
         else if (woke) ms = 0;
         if (wr && addr == 8'h08 && mst == 0) mbrp = wdata & 32'hFF;
         if (wr && addr == 8'h0C && mst == 0) mbt = wdata & 32'h1FF;
         if (wr && addr == 8'h20) mier = wdata & MASK;
         misr = (misr & ~((wr && addr == 8'h24) ? wdata : 32'h0)) | ({17'h0, evt} & MASK);
         mst = nst;
      end
   end

   function automatic logic [31:0] m_read(logic [7:0] a);
      logic [31:0] s;
      case (a)
         8'h00: return (mst != 0) ? 32'h2 : 32'h0;
         8'h04: return {30'h0, ml, ms};
         8'h08: return mbrp;
         8'h0C: return mbt;
         8'h18: begin
            if (mst == 0) return 32'h1;
            s = 0;
            if (mst == 1) s[3] = 1;
            if (mst == 2) s[1] = 1;
            if (mst == 3) s[2] = 1;
            s[6] = warn; s[8:7] = est; s[10] = full;
            return s;
         end
         8'h1C: return misr;
         8'h20: return mier;
         default: return 32'h0;
      endcase
   endfunction

   function automatic string tag_of(logic [7:0] a);
      case (a)
         8'h00: return "R5";
         8'h04: return "R4";
         8'h08, 8'h0C: return "R7";
         8'h18: return "R11";
         8'h1C: return "R8";
         8'h20: return "R10";
         8'h24: return "R9";
         default: return "R12";
      endcase
   endfunction

   task automatic chk(logic [31:0] got, logic [31:0] exp, string tag);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got 0x%08h expected 0x%08h at %0t", tag, got, exp, $time);
      end
   endtask

   // per-clock comparison
   always @(negedge clk) begin
      #5;
      if (rst_n && !done) begin
         chk(rdata, m_read(addr), tag_of(addr));
         chk({31'h0, irq}, {31'h0, (misr & mier) != 0}, "R10");
         chk({24'h0, brp}, mbrp, "R7");
         chk({23'h0, btim}, mbt, "R7");
         chk({30'h0, opmode}, mst, "R2");
      end
   end

   task automatic bus_write(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
      addr = a;
      #1;
      chk(rdata, exp, tag);
   endtask

   task automatic pulse(logic [14:0] v);
      @(negedge clk);
      evt = v;
      @(negedge clk);
      evt = '0;
   endtask

   task automatic finish_run();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      rd(8'h18, 32'h1, "R1");
      rd(8'h00, 32'h0, "R1");
      rd(8'h1C, 32'h0, "R1");
      rd(8'h08, 32'h0, "R1");
      // R7 writes in configuration
      bus_write(8'h08, 32'h1FF); rd(8'h08, 32'hFF, "R7");
      bus_write(8'h0C, 32'hFFFF); rd(8'h0C, 32'h1FF, "R7");
      // R2 enable to normal
      bus_write(8'h00, 32'h2);
      rd(8'h18, 32'h8, "R2");
      rd(8'h00, 32'h2, "R2");
      // R11 error fields outside configuration
      @(negedge clk); warn = 1; est = 2'd2; full = 1;
      rd(8'h18, 32'h548, "R11");
      // R7 ignored in normal mode
      bus_write(8'h08, 32'h12); rd(8'h08, 32'hFF, "R7");
      // R5 disable, R11 gating in configuration
      bus_write(8'h00, 32'h0); rd(8'h18, 32'h1, "R5");
      rd(8'h18, 32'h1, "R11");
      @(negedge clk); warn = 0; est = 0; full = 0;
      // R3 loopback
      bus_write(8'h04, 32'h2); bus_write(8'h00, 32'h2);
      rd(8'h18, 32'h2, "R3");
      bus_write(8'h00, 32'h0);
      // R4 sleep then wake
      bus_write(8'h04, 32'h1); bus_write(8'h00, 32'h2);
      rd(8'h18, 32'h8, "R4");
      @(negedge clk);
      rd(8'h18, 32'h4, "R4");
      pulse(15'h0800);
      rd(8'h18, 32'h8, "R4");
      rd(8'h04, 32'h0, "R4");
      rd(8'h1C, 32'h800, "R8");
      // R10 enable mask and irq level
      bus_write(8'h20, 32'hFFFF_FFFF); rd(8'h20, 32'h4FD7, "R10");
      chk({31'h0, irq}, 32'h1, "R10");
      // R9 zero write no effect, ones clear
      bus_write(8'h24, 32'h0); rd(8'h1C, 32'h800, "R9");
      bus_write(8'h24, 32'hFFFF_FFFF); rd(8'h1C, 32'h0, "R9");
      rd(8'h24, 32'h0, "R9");
      chk({31'h0, irq}, 32'h0, "R10");
      // R12 read-only and unmapped
      bus_write(8'h1C, 32'hFFFF); rd(8'h1C, 32'h0, "R12");
      bus_write(8'h18, 32'hFFFF); rd(8'h18, 32'h8, "R12");
      rd(8'h30, 32'h0, "R12");
      // R8 and R6: all events incl. bus-off
      pulse(15'h7FFF);
      rd(8'h1C, 32'h4FD7, "R8");
      rd(8'h18, 32'h1, "R6");
      rd(8'h00, 32'h0, "R6");
      // R9 set wins over clear in the same cycle
      bus_write(8'h24, 32'h1);
      @(negedge clk); addr = 8'h24; wdata = 32'h1; wr = 1; evt = 15'h1;
      @(negedge clk); wr = 0; evt = 0;
      rd(8'h1C, 32'h4FD7, "R9");
      // R10 single enable bit, unimplemented enable bit
      bus_write(8'h20, 32'h2); chk({31'h0, irq}, 32'h1, "R10");
      bus_write(8'h20, 32'h8); rd(8'h20, 32'h0, "R10");
      chk({31'h0, irq}, 32'h0, "R10");
      // R1 soft reset
      bus_write(8'h08, 32'h33);
      bus_write(8'h20, 32'h1);
      bus_write(8'h00, 32'h1);
      rd(8'h18, 32'h1, "R1");
      rd(8'h1C, 32'h0, "R1");
      rd(8'h20, 32'h0, "R1");
      rd(8'h08, 32'h0, "R1");
      rd(8'h00, 32'h0, "R1");
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule